// File: doc/BRIEF.md
# Eye-Region Pyramid Downscaler

This block turns a face bounding box into eight small grayscale images: four pyramid levels for the left-eye region and four for the right-eye region. After a start pulse it reads the upper half of the face from a single-port frame memory, one pixel per clock. It samples each eye quarter with nearest-neighbour fixed-point stepping into a 33-wide, 36-tall base image that is held in registers. The right-eye quarter is walked from its outer edge inward, so its image comes out already mirrored and needs no separate flip stage.

The three smaller levels of each eye are never fetched from memory. Each of them is a nearest-neighbour view of its eye's base registers. All eight images share the same storage and have their own combinational read ports, so a downstream transform stage can scan every level at the same time. A one-cycle done pulse marks the point at which all eight images are valid. The images hold their contents until the next accepted start.

Top module: `eye_pyr_top`

## Requirements
- R1: While reset is held and in the first cycle after it, done_o and mem_rd_o are low, and every read port returns 0.
- R2: For a box with inclusive corners (x0,y0) and (x1,y1), the eye quarters are hw = floor((x1-x0+1)/2) wide and hh = floor((y1-y0+1)/2) tall, both starting at row y0. The left quarter starts at column x0 and the right quarter ends at column x1.
- R3: Base pixel (c,r) of the left eye is taken from frame column x0 + ((c*sx)>>12) and frame row y0 + ((r*sy)>>12), where sx = floor(hw*4096/33) and sy = floor(hh*4096/36).
- R4: Base pixel (c,r) of the right eye is taken from frame column x1 - ((c*sx)>>12) and the same row as in R3, so the right image is mirrored.
- R5: After an accepted start, mem_rd_o is high for exactly 2*33*36 consecutive cycles beginning in the next cycle. The left image is read first, then the right, each row by row with columns ascending. Each address is row*FRAME_W + column.
- R6: mem_data_i is taken as the pixel for the address that was presented in the previous cycle.
- R7: done_o is high for exactly one cycle, two cycles after the last read cycle, and never in a read cycle.
- R8: A start that arrives while a fill is in progress, including the cycle between the last read and done_o, is ignored. The read sequence, the done timing and the image contents are unchanged.
- R9: Image index i = eye*4 + level (eye 0 left, 1 right). Levels 0..3 are 33x36, 31x34, 29x32 and 27x29 (width x height). Pixel (x,y) of level L equals base pixel ((x*floor(33*4096/W_L))>>12, (y*floor(36*4096/H_L))>>12) of the same eye, and level 0 is the base image itself.
- R10: A read coordinate with x >= W_L or y >= H_L returns 0.
- R11: A start accepted after done_o replaces all eight images with data from the new box.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a fill; accepted only when idle |
| face_x0_i | input | CRD_W | Box left column (inclusive) |
| face_y0_i | input | CRD_W | Box top row (inclusive) |
| face_x1_i | input | CRD_W | Box right column (inclusive) |
| face_y1_i | input | CRD_W | Box bottom row (inclusive) |
| done_o | output | 1 | One-cycle pulse: all images valid |
| mem_rd_o | output | 1 | Frame memory read strobe |
| mem_addr_o | output | ADDR_W | Frame memory address, row*FRAME_W+column |
| mem_data_i | input | PIX_W | Read data, one cycle after the address |
| rd_x_i | input | 8 x PC_W | Column per image read port |
| rd_y_i | input | 8 x PC_W | Row per image read port |
| rd_pix_o | output | 8 x PIX_W | Pixel per image read port |

## Verification
A wrong counter or accumulator in the fill sequencer shows up at once as a wrong memory address in the cycle where it occurs. Because the bench compares every address cycle by cycle, such an error is caught in that cycle. A slip in the read-data pipeline does not change the addresses: the pixels are simply stored one slot off. That error is visible only after done_o, when every pixel of all eight read ports is compared against values derived from the box. A wrong level step or a wrong mirror direction is caught by that same sweep. A sequencer that does not ignore a start while busy would change the address stream or the done timing within a cycle.

// File: rtl/eye_pyr_pkg.sv
package eye_pyr_pkg;
  localparam int N_EYE = 2;
  localparam int N_LVL = 4;
  localparam int N_IMG = N_EYE * N_LVL;
  localparam int LVL_W [N_LVL] = '{33, 31, 29, 27};
  localparam int LVL_H [N_LVL] = '{36, 34, 32, 29};
  localparam int BASE_W = LVL_W[0];
  localparam int BASE_H = LVL_H[0];
  localparam int PC_W = $clog2((BASE_W > BASE_H ? BASE_W : BASE_H) + 1);
  localparam int N_RD = N_EYE * BASE_W * BASE_H;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DRAIN} seq_st_e;

  function automatic int fx_step(int src, int dst, int frac);
    return (src << frac) / dst;
  endfunction
endpackage

// File: rtl/eye_pyr_seq.sv
module eye_pyr_seq
  import eye_pyr_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int FRAC_W  = 12,
  localparam int CRD_W  = $clog2(FRAME_W > FRAME_H ? FRAME_W : FRAME_H),
  localparam int ADDR_W = $clog2(FRAME_W * FRAME_H),
  localparam int ACC_W  = FRAC_W + CRD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CRD_W-1:0]  face_x0_i,
  input  logic [CRD_W-1:0]  face_y0_i,
  input  logic [CRD_W-1:0]  face_x1_i,
  input  logic [CRD_W-1:0]  face_y1_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wr_en_o,
  output logic              wr_eye_o,
  output logic [PC_W-1:0]   wr_row_o,
  output logic [PC_W-1:0]   wr_col_o,
  output logic              done_o
);
  seq_st_e st_q;
  logic [CRD_W-1:0] x0_q, x1_q, y0_q;
  logic [ACC_W-1:0] step_x_q, step_y_q, acc_x_q, acc_y_q;
  logic [PC_W-1:0]  col_q, row_q;
  logic             eye_q;
  logic             done_q;

  logic [CRD_W:0]   half_x, half_y;
  logic [CRD_W-1:0] off_x, off_y, src_x, src_y;
  logic             last_col, last_row;

  always_comb begin
    half_x   = ({1'b0, face_x1_i} - {1'b0, face_x0_i} + 1'b1) >> 1;
    half_y   = ({1'b0, face_y1_i} - {1'b0, face_y0_i} + 1'b1) >> 1;
    off_x    = CRD_W'(acc_x_q >> FRAC_W);
    off_y    = CRD_W'(acc_y_q >> FRAC_W);
    // right eye walks from the outer edge inward: mirrored without a flip
    src_x    = eye_q ? (x1_q - off_x) : (x0_q + off_x);
    src_y    = y0_q + off_y;
    last_col = (col_q == PC_W'(BASE_W - 1));
    last_row = (row_q == PC_W'(BASE_H - 1));
  end

  assign mem_rd_o   = (st_q == ST_FILL);
  assign mem_addr_o = ADDR_W'(32'(src_y) * 32'(FRAME_W) + 32'(src_x));
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      x0_q     <= '0;
      x1_q     <= '0;
      y0_q     <= '0;
      step_x_q <= '0;
      step_y_q <= '0;
      acc_x_q  <= '0;
      acc_y_q  <= '0;
      col_q    <= '0;
      row_q    <= '0;
      eye_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            x0_q     <= face_x0_i;
            x1_q     <= face_x1_i;
            y0_q     <= face_y0_i;
            step_x_q <= ACC_W'((ACC_W'(half_x) << FRAC_W) / ACC_W'(BASE_W));
            step_y_q <= ACC_W'((ACC_W'(half_y) << FRAC_W) / ACC_W'(BASE_H));
            acc_x_q  <= '0;
            acc_y_q  <= '0;
            col_q    <= '0;
            row_q    <= '0;
            eye_q    <= 1'b0;
            st_q     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (!last_col) begin
            col_q   <= col_q + 1'b1;
            acc_x_q <= acc_x_q + step_x_q;
          end else begin
            col_q   <= '0;
            acc_x_q <= '0;
            if (!last_row) begin
              row_q   <= row_q + 1'b1;
              acc_y_q <= acc_y_q + step_y_q;
            end else begin
              row_q   <= '0;
              acc_y_q <= '0;
              eye_q   <= 1'b1;
              if (eye_q) st_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // write side trails the read by the memory latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o  <= 1'b0;
      wr_eye_o <= 1'b0;
      wr_row_o <= '0;
      wr_col_o <= '0;
    end else begin
      wr_en_o  <= (st_q == ST_FILL);
      wr_eye_o <= eye_q;
      wr_row_o <= row_q;
      wr_col_o <= col_q;
    end
  end
endmodule

// File: rtl/eye_pyr_store.sv
module eye_pyr_store
  import eye_pyr_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_eye_i,
  input  logic [PC_W-1:0]  wr_row_i,
  input  logic [PC_W-1:0]  wr_col_i,
  input  logic [PIX_W-1:0] wr_data_i,
  output logic [PIX_W-1:0] img_o [N_EYE][BASE_H][BASE_W]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_EYE; e++)
        for (int r = 0; r < BASE_H; r++)
          for (int c = 0; c < BASE_W; c++)
            img_o[e][r][c] <= '0;
    end else if (wr_en_i) begin
      img_o[wr_eye_i][wr_row_i][wr_col_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/eye_pyr_lvl_rd.sv
module eye_pyr_lvl_rd
  import eye_pyr_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 12,
  parameter int LW     = 33,
  parameter int LH     = 36,
  localparam int STEP_X = fx_step(BASE_W, LW, FRAC_W),
  localparam int STEP_Y = fx_step(BASE_H, LH, FRAC_W)
) (
  input  logic [PIX_W-1:0] img_i [BASE_H][BASE_W],
  input  logic [PC_W-1:0]  x_i,
  input  logic [PC_W-1:0]  y_i,
  output logic [PIX_W-1:0] pix_o
);
  logic [PC_W-1:0] sx, sy;
  logic            in_rng;

  always_comb begin
    in_rng = (32'(x_i) < LW) && (32'(y_i) < LH);
    sx     = in_rng ? PC_W'((32'(x_i) * 32'(STEP_X)) >> FRAC_W) : '0;
    sy     = in_rng ? PC_W'((32'(y_i) * 32'(STEP_Y)) >> FRAC_W) : '0;
    pix_o  = in_rng ? img_i[sy][sx] : '0;
  end
endmodule

// File: rtl/eye_pyr_top.sv
module eye_pyr_top
  import eye_pyr_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int PIX_W   = 8,
  parameter int FRAC_W  = 12,
  localparam int CRD_W  = $clog2(FRAME_W > FRAME_H ? FRAME_W : FRAME_H),
  localparam int ADDR_W = $clog2(FRAME_W * FRAME_H)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [CRD_W-1:0]            face_x0_i,
  input  logic [CRD_W-1:0]            face_y0_i,
  input  logic [CRD_W-1:0]            face_x1_i,
  input  logic [CRD_W-1:0]            face_y1_i,
  output logic                        done_o,
  output logic                        mem_rd_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  input  logic [PIX_W-1:0]            mem_data_i,
  input  logic [N_IMG-1:0][PC_W-1:0]  rd_x_i,
  input  logic [N_IMG-1:0][PC_W-1:0]  rd_y_i,
  output logic [N_IMG-1:0][PIX_W-1:0] rd_pix_o
);
  logic             wr_en, wr_eye;
  logic [PC_W-1:0]  wr_row, wr_col;
  logic [PIX_W-1:0] img [N_EYE][BASE_H][BASE_W];

  eye_pyr_seq #(
    .FRAME_W (FRAME_W),
    .FRAME_H (FRAME_H),
    .FRAC_W  (FRAC_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .face_x0_i  (face_x0_i),
    .face_y0_i  (face_y0_i),
    .face_x1_i  (face_x1_i),
    .face_y1_i  (face_y1_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .wr_en_o    (wr_en),
    .wr_eye_o   (wr_eye),
    .wr_row_o   (wr_row),
    .wr_col_o   (wr_col),
    .done_o     (done_o)
  );

  eye_pyr_store #(.PIX_W(PIX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_eye_i  (wr_eye),
    .wr_row_i  (wr_row),
    .wr_col_i  (wr_col),
    .wr_data_i (mem_data_i),
    .img_o     (img)
  );

  for (genvar e = 0; e < N_EYE; e++) begin : g_eye
    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
      eye_pyr_lvl_rd #(
        .PIX_W  (PIX_W),
        .FRAC_W (FRAC_W),
        .LW     (LVL_W[l]),
        .LH     (LVL_H[l])
      ) u_rd (
        .img_i (img[e]),
        .x_i   (rd_x_i[e*N_LVL+l]),
        .y_i   (rd_y_i[e*N_LVL+l]),
        .pix_o (rd_pix_o[e*N_LVL+l])
      );
    end
  end
endmodule

// File: rtl/eye_pyr_chk.sv
module eye_pyr_chk
  import eye_pyr_pkg::*;
#(
  parameter int FRAME_W = 640,
  parameter int FRAME_H = 480,
  parameter int PIX_W   = 8,
  localparam int CRD_W  = $clog2(FRAME_W > FRAME_H ? FRAME_W : FRAME_H),
  localparam int ADDR_W = $clog2(FRAME_W * FRAME_H)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        start_i,
  input logic [CRD_W-1:0]            face_x0_i,
  input logic [CRD_W-1:0]            face_y0_i,
  input logic [CRD_W-1:0]            face_x1_i,
  input logic [CRD_W-1:0]            face_y1_i,
  input logic                        done_o,
  input logic                        mem_rd_o,
  input logic [ADDR_W-1:0]           mem_addr_o,
  input logic [PIX_W-1:0]            mem_data_i,
  input logic [N_IMG-1:0][PC_W-1:0]  rd_x_i,
  input logic [N_IMG-1:0][PC_W-1:0]  rd_y_i,
  input logic [N_IMG-1:0][PIX_W-1:0] rd_pix_o
);
  int unsigned rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_cnt <= 0;
    else if (done_o)   rd_cnt <= 0;
    else if (mem_rd_o) rd_cnt <= rd_cnt + 1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_AFTER_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_rd_o) |=> done_o); // R7
  AST_NO_READ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_rd_o); // R7
  AST_READ_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_rd_o) |-> rd_cnt == N_RD); // R5
  AST_ADDR_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> 32'(mem_addr_o) < FRAME_W * FRAME_H); // R5
  AST_READS_NEED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_o) |-> $past(start_i)); // R8

  for (genvar i = 0; i < N_IMG; i++) begin : g_oor
    AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(rd_x_i[i]) >= LVL_W[i % N_LVL] || 32'(rd_y_i[i]) >= LVL_H[i % N_LVL])
        |-> rd_pix_o[i] == '0); // R10
  end
endmodule

bind eye_pyr_top eye_pyr_chk #(
  .FRAME_W (FRAME_W),
  .FRAME_H (FRAME_H),
  .PIX_W   (PIX_W)
) u_chk (.*);

// File: tb/tb_eye_pyr_top.sv
`timescale 1ns/1ps
module tb_eye_pyr_top;
  import eye_pyr_pkg::*;
  localparam int FW = 640;
  localparam int FH = 480;
  localparam int PW = 8;
  localparam int FR = 12;
  localparam int CW = $clog2(FW);
  localparam int AW = $clog2(FW * FH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
  logic done, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_data = '0;
  logic [N_IMG-1:0][PC_W-1:0] rd_x = '0, rd_y = '0;
  logic [N_IMG-1:0][PW-1:0] rd_pix;

  int n_tests = 0;
  int n_fail = 0;
  int seed = 0;
  int bx0, by0, bx1, by1;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  eye_pyr_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .face_x0_i(x0), .face_y0_i(y0), .face_x1_i(x1), .face_y1_i(y1),
    .done_o(done), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .rd_x_i(rd_x), .rd_y_i(rd_y), .rd_pix_o(rd_pix)
  );

  function automatic int mem_val(int a);
    return ((a * 29) + ((a >> 7) * 3) + seed) & 255;
  endfunction

  // frame memory: one cycle of read latency
  always @(posedge clk) if (mem_rd) mem_data <= PW'(mem_val(int'(mem_addr)));

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int src_addr(int e, int r, int c);
    int hw = (bx1 - bx0 + 1) / 2;
    int hh = (by1 - by0 + 1) / 2;
    int sx = (hw << FR) / BASE_W;
    int sy = (hh << FR) / BASE_H;
    int ox = (c * sx) >> FR;
    int oy = (r * sy) >> FR;
    int fx = (e == 0) ? bx0 + ox : bx1 - ox;
    return (by0 + oy) * FW + fx;
  endfunction

  function automatic int exp_pix(int img, int x, int y);
    int e = img / N_LVL;
    int l = img % N_LVL;
    int bc, br;
    if (x >= LVL_W[l] || y >= LVL_H[l]) return 0;
    bc = (x * ((BASE_W << FR) / LVL_W[l])) >> FR;
    br = (y * ((BASE_H << FR) / LVL_H[l])) >> FR;
    return mem_val(src_addr(e, br, bc));
  endfunction

  task automatic run_box(int ax0, int ay0, int ax1, int ay1, int sd);
    int q[$];
    seed = sd;
    bx0 = ax0; by0 = ay0; bx1 = ax1; by1 = ay1;
    for (int e = 0; e < N_EYE; e++)
      for (int r = 0; r < BASE_H; r++)
        for (int c = 0; c < BASE_W; c++)
          q.push_back(src_addr(e, r, c));
    @(negedge clk);
    x0 = CW'(ax0); y0 = CW'(ay0); x1 = CW'(ax1); y1 = CW'(ay1);
    start = 1'b1;
    for (int k = 1; k <= N_RD + 6; k++) begin
      @(negedge clk);
      start = 1'b0;
      check(mem_rd == (k <= N_RD), (k > N_RD + 2) ? "R8 no rerun" : "R5 read strobe",
            int'(mem_rd), int'(k <= N_RD));
      if (k <= N_RD)
        check(int'(mem_addr) == q[k-1], (k > N_RD / 2) ? "R5 R4 addr" : "R5 R3 addr",
              int'(mem_addr), q[k-1]);
      check(done == (k == N_RD + 2), "R7 done timing", int'(done), int'(k == N_RD + 2));
      // starts during fill and in the cycle before done must be ignored (R8)
      if (k == 40 || k == N_RD + 1) begin
        start = 1'b1;
        x0 = '0; y0 = '0; x1 = CW'(3); y1 = CW'(5);
      end
    end
  endtask

  task automatic check_images(string tag);
    for (int i = 0; i < N_IMG; i++) begin
      int l = i % N_LVL;
      string req = (l == 0) ? ((i < N_LVL) ? "R2 R3 R6" : "R4 R6") : "R9";
      for (int y = 0; y < LVL_H[l]; y++)
        for (int x = 0; x < LVL_W[l]; x++) begin
          rd_x[i] = PC_W'(x);
          rd_y[i] = PC_W'(y);
          #1;
          check(int'(rd_pix[i]) == exp_pix(i, x, y), {tag, " ", req},
                int'(rd_pix[i]), exp_pix(i, x, y));
        end
      rd_x[i] = PC_W'(LVL_W[l]); rd_y[i] = '0; #1;
      check(rd_pix[i] == '0, "R10 x out of range", int'(rd_pix[i]), 0);
      rd_x[i] = '0; rd_y[i] = PC_W'(LVL_H[l]); #1;
      check(rd_pix[i] == '0, "R10 y out of range", int'(rd_pix[i]), 0);
    end
    // all ports at once, distinct coordinates
    for (int i = 0; i < N_IMG; i++) begin
      rd_x[i] = PC_W'(LVL_W[i % N_LVL] - 1 - i);
      rd_y[i] = PC_W'(i + 3);
    end
    #1;
    for (int i = 0; i < N_IMG; i++)
      check(int'(rd_pix[i]) == exp_pix(i, int'(rd_x[i]), int'(rd_y[i])), {tag, " R9 parallel"},
            int'(rd_pix[i]), exp_pix(i, int'(rd_x[i]), int'(rd_y[i])));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(mem_rd == 1'b0, "R1 rd in reset", int'(mem_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && mem_rd == 1'b0, "R1 after reset", int'({done, mem_rd}), 0);
    for (int i = 0; i < N_IMG; i++) begin
      rd_x[i] = PC_W'(i); rd_y[i] = PC_W'(2 * i);
    end
    #1;
    for (int i = 0; i < N_IMG; i++)
      check(rd_pix[i] == '0, "R1 image cleared", int'(rd_pix[i]), 0);

    run_box(100, 80, 259, 239, 11);
    check_images("run1");
    // R11: second box with odd extents and a new frame
    run_box(301, 40, 497, 260, 97);
    check_images("R11 run2");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule